// File: doc/BRIEF.md
# Multi-Cycle Shared-Resource Processor Datapath

This block is the 32-bit datapath of a load/store processor that spreads every instruction over several clock cycles. A single memory port serves both instruction fetch and data access. A single ALU handles the PC increment, the branch target, effective addresses and register-to-register arithmetic. Each of these runs in a different cycle.

Holding registers keep each unit's result for the next cycle: an instruction register, a memory data register, two operand latches and an ALU result latch. The datapath holds no sequencing logic. An external control unit drives the multiplexer selects and write enables every cycle. The datapath returns the opcode and function fields of the held instruction and a flag that is set when the ALU result is zero.

The datapath contains the register file, the sign extension, the two-bit shifts, the jump-target assembly and the program counter. The memory itself sits outside the block. Its read data arrives combinationally for the address presented, and writes happen at the clock edge.

Top module: `mcdp_top`

## Requirements
- R1: A synchronous active-high reset clears the PC to 0. With `addr_sel`=0 the memory address then reads 0.
- R2: In a fetch cycle (`ir_wr`=1, `pc_wr`=1, `srca_sel`=0, `srcb_sel`=01, `alu_mode`=00, `pc_sel`=00) the instruction register takes the memory word at the PC, and the PC becomes PC+4. After that edge, `opcode` shows IR[31:26] (a load word reads 6'b100011) and `funct` shows IR[5:0].
- R3: The memory address is the PC when `addr_sel`=0 and the ALU result latch when `addr_sel`=1. The store data is the B operand latch, which holds the register selected by IR[20:16].
- R4: A decode cycle (`srca_sel`=0, `srcb_sel`=11, `alu_mode`=00) leaves the incremented PC plus the sign-extended IR[15:0] shifted left by two in the ALU result latch, whatever the instruction.
- R5: With `srca_sel`=1 and `srcb_sel`=10 the effective address is A plus the sign-extended IR[15:0], including for negative offsets. With `wb_sel`=1, `dst_sel`=0 and `reg_wr`=1, the memory data register is written to the register at IR[20:16].
- R6: With `alu_mode`=10 the ALU applies IR[5:0] to A and B: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A set-less-than. Add and subtract wrap modulo 2^32. With `dst_sel`=1, `wb_sel`=0 and `reg_wr`=1, the latched result goes to the register at IR[15:11].
- R7: Set-less-than compares A and B as signed two's-complement values and yields 1 or 0.
- R8: Register 0 always reads as zero. Writes to it, from either an ALU result or a load, have no effect.
- R9: In a branch cycle (`alu_mode`=01 subtract, `pc_sel`=01, `pc_wr_cond`=1) the PC takes the ALU result latch only when A equals B. `alu_zero` is 1 exactly then. Otherwise the PC keeps its incremented value.
- R10: With `pc_sel`=10 and `pc_wr`=1 the PC becomes the current PC's upper four bits, then IR[25:0], then two zero bits.
- R11: When `pc_wr` and `pc_wr_cond` are both 0 the PC keeps its value. When `ir_wr` is 0 the instruction register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write qualified by ALU zero |
| addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU result latch |
| ir_wr | input | 1 | Instruction register load |
| reg_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination: 0 IR[20:16], 1 IR[15:11] |
| wb_sel | input | 1 | Write data: 0 ALU result latch, 1 memory data register |
| srca_sel | input | 1 | ALU A input: 0 PC, 1 A latch |
| srcb_sel | input | 2 | ALU B input: 00 B latch, 01 constant 4, 10 sign-extended immediate, 11 that shifted left by 2 |
| alu_mode | input | 2 | 00 add, 01 subtract, 10 decode function field |
| pc_sel | input | 2 | PC source: 00 ALU output, 01 ALU result latch, 10 jump target |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (B latch) |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| alu_zero | output | 1 | ALU output equals zero |

## Verification
The bench goes after the values that cross cycle boundaries. If the branch target were formed from the pre-increment PC, or without the two-bit shift, the target probed during a branch would be off by 4 or by a factor of four. A backward branch and a store with a negative offset would expose a missing sign extension as an address far above the expected one. Set-less-than is driven with operands of opposite sign, and add with a carry into the sign bit, so an unsigned compare or a saturating add shows up as a wrong stored word. Two jumps, the second from above 0x0FFFFFFC, check that the upper PC bits come from the incremented PC rather than zeros. Writes to register 0 are read back through a store, and an idle cycle is followed by a fetch at the same address, so a lost write guard or a free-running PC is caught.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
    localparam int XLEN = 32;

    // Instruction field view; bit positions fixed by the instruction encoding.
    typedef struct packed {
        logic [5:0] opc;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] sh;
        logic [5:0] fn;
    } instr_t;

    typedef enum logic [1:0] {AM_ADD = 2'b00, AM_SUB = 2'b01, AM_FUNCT = 2'b10} alu_mode_e;
    typedef enum logic [1:0] {SB_REG = 2'b00, SB_FOUR = 2'b01, SB_IMM = 2'b10, SB_IMM4 = 2'b11} srcb_e;
    typedef enum logic [1:0] {PS_ALU = 2'b00, PS_LATCH = 2'b01, PS_JUMP = 2'b10} pcsel_e;
    typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT, OP_ZERO} alu_op_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    function automatic alu_op_e alu_decode(input logic [1:0] mode, input logic [5:0] fn);
        alu_op_e op;
        case (mode)
            AM_ADD:   op = OP_ADD;
            AM_SUB:   op = OP_SUB;
            AM_FUNCT: begin
                case (fn)
                    FN_ADD:  op = OP_ADD;
                    FN_SUB:  op = OP_SUB;
                    FN_AND:  op = OP_AND;
                    FN_OR:   op = OP_OR;
                    FN_SLT:  op = OP_SLT;
                    default: op = OP_ZERO;
                endcase
            end
            default:  op = OP_ZERO;
        endcase
        return op;
    endfunction
endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
    import mcdp_pkg::*;
#(
    parameter int WIDTH = XLEN,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] ra,
    input  logic [$clog2(DEPTH)-1:0] rb,
    input  logic [$clog2(DEPTH)-1:0] wa,
    input  logic [WIDTH-1:0]         wd,
    input  logic                     we,
    output logic [WIDTH-1:0]         rda,
    output logic [WIDTH-1:0]         rdb
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] regs [DEPTH];

    // Entry 0 is never loaded, so it reads zero forever.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && (wa == AW'(i)) && (i != 0)) begin
                regs[i] <= wd;
            end
        end
    end

    assign rda = regs[ra];
    assign rdb = regs[rb];
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_SLT:  y = WIDTH'($signed(a) < $signed(b));
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

    always_comb begin
        if (op == OP_SLT) begin
            AST_SLT_BOOLEAN: assert (y[WIDTH-1:1] == '0); // R7
        end
    end
endmodule

// File: rtl/mcdp_top.sv
module mcdp_top
    import mcdp_pkg::*;
#(
    parameter int DW      = XLEN,
    parameter int REG_NUM = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pc_wr,
    input  logic          pc_wr_cond,
    input  logic          addr_sel,
    input  logic          ir_wr,
    input  logic          reg_wr,
    input  logic          dst_sel,
    input  logic          wb_sel,
    input  logic          srca_sel,
    input  logic [1:0]    srcb_sel,
    input  logic [1:0]    alu_mode,
    input  logic [1:0]    pc_sel,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [5:0]    opcode,
    output logic [5:0]    funct,
    output logic          alu_zero
);
    localparam int RAW = $clog2(REG_NUM);
    localparam int IMM_W = 16;

    logic [DW-1:0] pc_q, a_q, b_q, res_q, mdr_q;
    instr_t        ir_q;

    logic [DW-1:0] rda, rdb, wdata, imm_ext, imm_sh, opa, opb, alu_y, pc_next, jmp_tgt;
    logic [RAW-1:0] waddr;
    alu_op_e       alu_op;
    logic          pc_load;

    // Operand and immediate shaping
    assign imm_ext = {{(DW-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign imm_sh  = {imm_ext[DW-3:0], 2'b00};
    assign jmp_tgt = {pc_q[DW-1:DW-4], ir_q[25:0], 2'b00};

    assign waddr = dst_sel ? RAW'(ir_q.rd) : RAW'(ir_q.rt);
    assign wdata = wb_sel ? mdr_q : res_q;

    mcdp_regfile #(.WIDTH(DW), .DEPTH(REG_NUM)) i_regs (
        .clk (clk),
        .rst (rst),
        .ra  (RAW'(ir_q.rs)),
        .rb  (RAW'(ir_q.rt)),
        .wa  (waddr),
        .wd  (wdata),
        .we  (reg_wr),
        .rda (rda),
        .rdb (rdb)
    );

    assign opa = srca_sel ? a_q : pc_q;

    always_comb begin
        case (srcb_e'(srcb_sel))
            SB_REG:  opb = b_q;
            SB_FOUR: opb = DW'(4);
            SB_IMM:  opb = imm_ext;
            default: opb = imm_sh;
        endcase
    end

    assign alu_op = alu_decode(alu_mode, ir_q.fn);

    mcdp_alu #(.WIDTH(DW)) i_alu (
        .op   (alu_op),
        .a    (opa),
        .b    (opb),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        case (pcsel_e'(pc_sel))
            PS_LATCH: pc_next = res_q;
            PS_JUMP:  pc_next = jmp_tgt;
            default:  pc_next = alu_y;
        endcase
    end

    assign pc_load = pc_wr | (pc_wr_cond & alu_zero);

    // Holding registers: PC and IR are enabled, the others load every cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
            mdr_q <= '0;
        end else begin
            if (pc_load) pc_q <= pc_next;
            if (ir_wr)   ir_q <= instr_t'(mem_rdata);
            a_q   <= rda;
            b_q   <= rdb;
            res_q <= alu_y;
            mdr_q <= mem_rdata;
        end
    end

    assign mem_addr  = addr_sel ? res_q : pc_q;
    assign mem_wdata = b_q;
    assign opcode    = ir_q.opc;
    assign funct     = ir_q.fn;

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !pc_wr_cond) |=> $stable(pc_q)); // R11
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir_q)); // R11
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && !srca_sel && srcb_sel == 2'b01 && alu_mode == 2'b00 && pc_sel == 2'b00)
        |=> pc_q == $past(pc_q) + DW'(4)); // R2
    AST_BRANCH_TAKE: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_cond && !pc_wr && alu_zero && pc_sel == 2'b01) |=> pc_q == $past(res_q)); // R9
    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        ($past(ir_q.rs) == 5'd0) |-> a_q == '0); // R8
endmodule

// File: tb/test_mcdp_top.sv
module test_mcdp_top;
    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       ir_wr;
        logic       reg_wr;
        logic       dst_sel;
        logic       wb_sel;
        logic       srca;
        logic [1:0] srcb;
        logic [1:0] mode;
        logic [1:0] pcs;
        logic       mem_we;
    } ctl_t;

    localparam ctl_t C_IDLE  = '0;
    localparam ctl_t C_FETCH = '{pc_wr:1'b1, ir_wr:1'b1, srcb:2'b01, default:'0};
    localparam ctl_t C_DEC   = '{srcb:2'b11, default:'0};
    localparam ctl_t C_MADDR = '{srca:1'b1, srcb:2'b10, default:'0};
    localparam ctl_t C_LRD   = '{addr_sel:1'b1, default:'0};
    localparam ctl_t C_LWB   = '{reg_wr:1'b1, wb_sel:1'b1, default:'0};
    localparam ctl_t C_SWR   = '{addr_sel:1'b1, mem_we:1'b1, default:'0};
    localparam ctl_t C_REX   = '{srca:1'b1, mode:2'b10, default:'0};
    localparam ctl_t C_RWB   = '{reg_wr:1'b1, dst_sel:1'b1, default:'0};
    localparam ctl_t C_BEQ   = '{srca:1'b1, mode:2'b01, pcs:2'b01, pc_wr_cond:1'b1, addr_sel:1'b1, default:'0};
    localparam ctl_t C_JMP   = '{pc_wr:1'b1, pcs:2'b10, default:'0};

    // {funct, a, b, expected}
    localparam int NV = 7;
    localparam logic [101:0] VEC [NV] = '{
        {6'h20, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
        {6'h22, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
        {6'h24, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},
        {6'h25, 32'hF0F0_0000, 32'h0000_0F0F, 32'hF0F0_0F0F},
        {6'h2A, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
        {6'h2A, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},
        {6'h20, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    ctl_t        ctl = C_IDLE;
    logic [31:0] mem [256];
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic [5:0]  opcode, funct;
    logic        alu_zero;
    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] exp_pc = '0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    mcdp_top i_mcdp_top (
        .clk        (clk),
        .rst        (rst),
        .pc_wr      (ctl.pc_wr),
        .pc_wr_cond (ctl.pc_wr_cond),
        .addr_sel   (ctl.addr_sel),
        .ir_wr      (ctl.ir_wr),
        .reg_wr     (ctl.reg_wr),
        .dst_sel    (ctl.dst_sel),
        .wb_sel     (ctl.wb_sel),
        .srca_sel   (ctl.srca),
        .srcb_sel   (ctl.srcb),
        .alu_mode   (ctl.mode),
        .pc_sel     (ctl.pcs),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .opcode     (opcode),
        .funct      (funct),
        .alu_zero   (alu_zero)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic step(input ctl_t c);
        ctl = c;
        #1;
    endtask

    task automatic adv();
        logic        we = ctl.mem_we;
        logic [7:0]  ix = mem_addr[9:2];
        logic [31:0] wd = mem_wdata;
        @(posedge clk);
        if (we) mem[ix] = wd;
        #1;
    endtask

    task automatic run(input ctl_t c);
        step(c);
        adv();
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    task automatic fetch(input logic [31:0] instr);
        mem[exp_pc[9:2]] = instr;
        step(C_FETCH);
        check(mem_addr == exp_pc, "R2 fetch address", mem_addr, exp_pc);
        adv();
        exp_pc = exp_pc + 32'd4;
        check({opcode, funct} == {instr[31:26], instr[5:0]}, "R2 opcode/funct", {20'd0, opcode, funct}, {20'd0, instr[31:26], instr[5:0]});
        run(C_DEC);
    endtask

    task automatic do_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
        fetch(enc_i(6'h23, rs, rt, imm));
        run(C_MADDR);
        run(C_LRD);
        run(C_LWB);
    endtask

    task automatic do_sw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                         input logic [31:0] ea, input logic [31:0] data, input string req);
        fetch(enc_i(6'h2B, rs, rt, imm));
        run(C_MADDR);
        step(C_SWR);
        check(mem_addr == ea, {req, " store address"}, mem_addr, ea);
        check(mem_wdata == data, {req, " store data"}, mem_wdata, data);
        adv();
    endtask

    task automatic do_r(input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt, input logic [5:0] fn);
        fetch(enc_r(rs, rt, rd, fn));
        run(C_REX);
        run(C_RWB);
    endtask

    task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off, input logic taken);
        logic [31:0] tgt;
        fetch(enc_i(6'h04, rs, rt, off));
        tgt = exp_pc + {{14{off[15]}}, off, 2'b00};
        step(C_BEQ);
        check(mem_addr == tgt, "R4 decode branch target", mem_addr, tgt);
        check(alu_zero == taken, "R9 zero flag", {31'd0, alu_zero}, {31'd0, taken});
        adv();
        if (taken) exp_pc = tgt;
    endtask

    task automatic do_j(input logic [25:0] t);
        fetch({6'h02, t});
        run(C_JMP);
        exp_pc = {exp_pc[31:28], t, 2'b00};
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[200] = 32'hDEAD_BEEF;   // 0x320
        mem[201] = 32'h0000_0340;   // 0x324
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state
        step(C_IDLE);
        check(mem_addr == 32'd0, "R1 PC after reset", mem_addr, 32'd0);

        // R5/R3: load, then store through a negative offset
        do_lw(5'd1, 5'd0, 16'h0320);
        do_lw(5'd2, 5'd0, 16'h0324);
        do_sw(5'd1, 5'd2, 16'hFFF8, 32'h0000_0338, 32'hDEAD_BEEF, "R5 R3");
        check(mem[206] == 32'hDEAD_BEEF, "R5 memory word", mem[206], 32'hDEAD_BEEF);

        // R6/R7: vector table of register-register operations
        for (int v = 0; v < NV; v++) begin
            mem[192] = VEC[v][95:64];
            mem[193] = VEC[v][63:32];
            do_lw(5'd8, 5'd0, 16'h0300);
            do_lw(5'd9, 5'd0, 16'h0304);
            do_r(5'd10, 5'd8, 5'd9, VEC[v][101:96]);
            do_sw(5'd10, 5'd0, 16'h0308, 32'h0000_0308, VEC[v][31:0], "R6 R7 result");
        end

        // R8: register 0 ignores ALU and load writes
        do_r(5'd0, 5'd1, 5'd1, 6'h20);
        do_sw(5'd0, 5'd0, 16'h030C, 32'h0000_030C, 32'd0, "R8 after ALU write");
        do_lw(5'd0, 5'd0, 16'h0320);
        do_sw(5'd0, 5'd0, 16'h030C, 32'h0000_030C, 32'd0, "R8 after load write");

        // R11: idle cycles leave PC and IR unchanged
        run(C_IDLE);
        step(C_IDLE);
        check(mem_addr == exp_pc, "R11 PC held", mem_addr, exp_pc);
        check(opcode == 6'h2B, "R11 IR held", {26'd0, opcode}, 32'h2B);
        adv();

        // R9/R4: branch not taken, then taken backwards
        do_beq(5'd1, 5'd2, 16'h0005, 1'b0);
        do_beq(5'd1, 5'd1, 16'hFFFD, 1'b1);
        do_r(5'd11, 5'd1, 5'd2, 6'h25);
        do_sw(5'd11, 5'd0, 16'h0310, 32'h0000_0310, 32'hDEAD_BFEF, "R9 after taken branch");

        // R10: jumps, second one keeps upper PC bits
        do_j(26'h3FF_FFFF);
        do_j(26'h000_0040);
        step(C_IDLE);
        check(mem_addr == 32'h1000_0100, "R10 jump with upper PC bits", mem_addr, 32'h1000_0100);
        do_r(5'd12, 5'd2, 5'd2, 6'h20);
        do_sw(5'd12, 5'd0, 16'h0314, 32'h0000_0314, 32'h0000_0680, "R10 execution after jump");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule